// File: doc/BRIEF.md
# Programmable buzzer divider output

This block drives a single pin with a square wave of about 50% duty, suitable for a piezoelectric buzzer. Two free-running binary counters form the divider chain. A high-speed counter advances on a high-speed clock-enable tick, and a low-speed counter advances on a low-speed tick. Both run on one system clock. One of four counter bits is chosen as the tone. The choice depends on a two-bit select field, a source bit, and an operating-mode input. When that input is high (slow or sleep operation), the low-speed counter is forced as the source.

A byte-wide control register holds the enable, the select field and the source bit. The remaining bits are stored and read back unchanged. The pin combines the tone with the port output-latch bit, and is registered so that a tap change cannot glitch it. The select field is protected: a write that would change it while the output is enabled keeps the old field.

Top module: `buzzer_divout`

## Requirements
- R1: After reset the control register reads 0x00 and the pin is 0.
- R2: A write stores the byte on the next clock. Read data always shows the stored byte. Bit 7 is the enable, bits 6:5 are the select code, bit 4 is the source bit, and bits 3:0 are plain storage.
- R3: With the high-speed source, select codes 0, 1, 2 and 3 pick high-speed counter bits 12, 11, 10 and 9. These give a tick rate divided by 8192, 4096, 2048 and 1024.
- R4: With the low-speed source, select codes 0, 1, 2 and 3 pick low-speed counter bits 4, 3, 2 and 1. These give a tick rate divided by 32, 16, 8 and 4.
- R5: When the mode input is 0, source bit 0 picks the high-speed counter and source bit 1 picks the low-speed counter.
- R6: When the mode input is 1, the low-speed counter is used whatever the source bit holds.
- R7: While the enable is 0, the pin equals the port latch bit one clock later.
- R8: While the enable is 1, the pin equals (selected tap AND port latch), sampled at the previous clock edge.
- R9: If the enable is 1 when a write lands, bits 6:5 keep their old value. This includes a write that also clears the enable. All other bits take the written value.
- R10: Each counter starts at 0, advances by one on each clock with its tick high, holds otherwise, and wraps. With the output enabled, code 0, high-speed source, a tick every clock and the latch at 1, the pin is high for exactly 4096 of any 8192 consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| fast_tick | input | 1 | High-speed divider advance enable |
| slow_tick | input | 1 | Low-speed divider advance enable |
| low_power_mode | input | 1 | 1 in slow/sleep operation; forces the low-speed source |
| port_latch | input | 1 | Port output-latch bit |
| pin_out | output | 1 | Registered buzzer pin |

## Verification
The bench builds the block with its default widths: a 13-bit high-speed counter and a 5-bit low-speed counter. With the high-speed tick held high every clock, even the slowest tap, at 8192 clocks per period, completes full periods in a short run. This makes the exact 50% duty count reachable. It also lets every select code be visited on both sources, and with the mode input forced. The reference model keeps the counters as integers and derives each tap by shifting, so rejected select writes and latch gating are compared clock by clock.

// File: rtl/buzz_pkg.sv
package buzz_pkg;
  localparam int REG_W = 8;
  localparam int SEL_W = 2;
  localparam int NTAP  = 1 << SEL_W;

  typedef struct packed {
    logic             en;
    logic [SEL_W-1:0] sel;
    logic             src;
    logic [3:0]       spare;
  } ctrl_t;

  // counter bit that a select code picks in a chain of the given width
  function automatic int tap_bit(input int width, input int code);
    return width - 1 - code;
  endfunction

  // register update rule: select field frozen while enabled
  function automatic ctrl_t apply_write(input ctrl_t cur, input logic [REG_W-1:0] wd);
    ctrl_t nxt;
    nxt = ctrl_t'(wd);
    if (cur.en) nxt.sel = cur.sel;
    return nxt;
  endfunction
endpackage

// File: rtl/buzz_ctrl_reg.sv
module buzz_ctrl_reg
  import buzz_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output ctrl_t            ctrl_q,
  output logic             sel_blocked
);
  ctrl_t wr_view;

  assign wr_view     = ctrl_t'(wdata);
  assign sel_blocked = wr && ctrl_q.en && (wr_view.sel != ctrl_q.sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ctrl_q <= '0;
    else if (wr) ctrl_q <= apply_write(ctrl_q, wdata);
  end

  // R9
  sel_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.en |=> $stable(ctrl_q.sel));

  // R2
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !ctrl_q.en) |=> (ctrl_q == $past(wdata)));

  // R9
  blocked_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_blocked |=> (ctrl_q.sel != $past(wr_view.sel)));
endmodule

// File: rtl/buzz_div_chain.sv
module buzz_div_chain #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= cnt + W'(1);
  end

  // R10
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == $past(cnt) + W'(1)));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));
endmodule

// File: rtl/buzz_tap_mux.sv
module buzz_tap_mux
  import buzz_pkg::*;
#(
  parameter int FAST_W = 13,
  parameter int SLOW_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FAST_W-1:0] fast_cnt,
  input  logic [SLOW_W-1:0] slow_cnt,
  input  logic [SEL_W-1:0]  sel,
  input  logic              src,
  input  logic              low_power,
  output logic              use_slow,
  output logic              tap
);
  logic [NTAP-1:0] fast_taps;
  logic [NTAP-1:0] slow_taps;

  for (genvar i = 0; i < NTAP; i++) begin : g_taps
    assign fast_taps[i] = fast_cnt[tap_bit(FAST_W, i)];
    assign slow_taps[i] = slow_cnt[tap_bit(SLOW_W, i)];
  end

  assign use_slow = low_power | src;
  assign tap      = use_slow ? slow_taps[sel] : fast_taps[sel];

  // R6
  lp_forces_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_power |-> use_slow);

  // R5
  normal_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !low_power |-> (use_slow == src));
endmodule

// File: rtl/buzzer_divout.sv
module buzzer_divout
  import buzz_pkg::*;
#(
  parameter int FAST_W = 13,
  parameter int SLOW_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             fast_tick,
  input  logic             slow_tick,
  input  logic             low_power_mode,
  input  logic             port_latch,
  output logic             pin_out
);
  ctrl_t             ctrl;
  logic              sel_blocked;
  logic [FAST_W-1:0] fast_cnt;
  logic [SLOW_W-1:0] slow_cnt;
  logic              use_slow;
  logic              tap;
  logic              pin_d;

  buzz_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata),
    .ctrl_q(ctrl), .sel_blocked(sel_blocked)
  );

  buzz_div_chain #(.W(FAST_W)) u_fast (
    .clk(clk), .rst_n(rst_n), .tick(fast_tick), .cnt(fast_cnt)
  );

  buzz_div_chain #(.W(SLOW_W)) u_slow (
    .clk(clk), .rst_n(rst_n), .tick(slow_tick), .cnt(slow_cnt)
  );

  buzz_tap_mux #(.FAST_W(FAST_W), .SLOW_W(SLOW_W)) u_mux (
    .clk(clk), .rst_n(rst_n), .fast_cnt(fast_cnt), .slow_cnt(slow_cnt),
    .sel(ctrl.sel), .src(ctrl.src), .low_power(low_power_mode),
    .use_slow(use_slow), .tap(tap)
  );

  assign reg_rdata = ctrl;
  assign pin_d     = ctrl.en ? (tap & port_latch) : port_latch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_out <= 1'b0;
    else        pin_out <= pin_d;
  end

  // R7
  follow_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.en |=> (pin_out == $past(port_latch)));

  // R8
  latch_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !port_latch |=> !pin_out);

  // R8
  tone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.en && port_latch) |=> (pin_out == $past(tap)));
endmodule

// File: tb/buzzer_divout_bench.sv
module buzzer_divout_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       fast_tick = 1'b0;
  logic       slow_tick = 1'b0;
  logic       low_power_mode = 1'b0;
  logic       port_latch = 1'b0;
  logic       pin_out;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cyc = 0;
  bit    live = 1'b0;
  string cur_req = "R7";

  // reference model state
  int        m_fast = 0;
  int        m_slow = 0;
  bit [7:0]  m_reg = 8'h00;
  bit        m_pin = 1'b0;

  always #2 clk = ~clk;

  buzzer_divout u_buzzer_divout (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .fast_tick(fast_tick), .slow_tick(slow_tick),
    .low_power_mode(low_power_mode), .port_latch(port_latch), .pin_out(pin_out)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_fast = 0; m_slow = 0; m_reg = 8'h00; m_pin = 1'b0;
    end else begin
      int  code;
      bit  slow_src;
      bit  tone;
      bit [7:0] nr;
      code     = int'(m_reg[6:5]);
      slow_src = low_power_mode || m_reg[4];
      tone     = slow_src ? ((m_slow >> (4 - code)) & 1) != 0
                          : ((m_fast >> (12 - code)) & 1) != 0;
      m_pin    = m_reg[7] ? (tone && port_latch) : port_latch;
      if (reg_wr) begin
        nr = reg_wdata;
        if (m_reg[7]) nr[6:5] = m_reg[6:5];
        m_reg = nr;
      end
      if (fast_tick) m_fast = (m_fast + 1) % 8192;
      if (slow_tick) m_slow = (m_slow + 1) % 32;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (live && rst_n) begin
      check(cur_req, "pin", int'(pin_out), int'(m_pin));
      check("R2", "rdata", int'(reg_rdata), int'(m_reg));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic wr(input bit [7:0] b);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = b;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic run(input int n, input bit gate);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      slow_tick = (i % 3) == 0;
      if (gate) port_latch = (i % 331) < 290;
    end
  endtask

  initial begin
    int hi;
    repeat (3) @(negedge clk);
    // R1
    check("R1", "reset rdata", int'(reg_rdata), 0);
    check("R1", "reset pin", int'(pin_out), 0);
    @(negedge clk); rst_n = 1'b1;
    live = 1'b1;

    // R2 / R7: disabled, pin follows latch
    cur_req = "R7";
    wr(8'h5A);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); port_latch = (i % 5) < 2;
    end
    wr(8'h00);

    // R3 / R10: high-speed taps, tick every clock
    fast_tick = 1'b1;
    port_latch = 1'b1;
    cur_req = "R10";
    wr(8'h80);
    hi = 0;
    for (int i = 0; i < 8192; i++) begin
      @(negedge clk);
      if (pin_out) hi++;
    end
    check("R10", "duty high count", hi, 4096);
    cur_req = "R3 R8";
    run(1500, 1'b1);
    for (int c = 1; c < 4; c++) begin
      wr(8'h00 | 8'(c << 5));
      wr(8'h80 | 8'(c << 5));
      run(3 * (8192 >> c), 1'b1);
      wr(8'h00 | 8'(c << 5));
    end

    // R4 / R5: low-speed source via register bit
    cur_req = "R4 R5";
    for (int c = 0; c < 4; c++) begin
      wr(8'h10 | 8'(c << 5));
      wr(8'h90 | 8'(c << 5));
      fast_tick = (c % 2) == 0;
      run(400, 1'b1);
      wr(8'h10 | 8'(c << 5));
    end
    fast_tick = 1'b1;

    // R6: mode input forces low-speed source
    cur_req = "R6";
    low_power_mode = 1'b1;
    for (int c = 0; c < 4; c++) begin
      wr(8'h00 | 8'(c << 5));
      wr(8'h80 | 8'(c << 5));
      run(400, 1'b1);
      wr(8'h00 | 8'(c << 5));
    end
    low_power_mode = 1'b0;

    // R9: select changes blocked while enabled
    cur_req = "R9";
    wr(8'h20);
    wr(8'hA0);
    wr(8'hC3);
    @(negedge clk);
    check("R9", "sel kept while enabled", int'(reg_rdata), 8'hA3);
    run(200, 1'b0);
    wr(8'h45);
    @(negedge clk);
    check("R9", "sel kept on disabling write", int'(reg_rdata), 8'h25);
    wr(8'h47);
    @(negedge clk);
    check("R9", "sel written when disabled", int'(reg_rdata), 8'h47);
    run(50, 1'b1);

    live = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule